// File: doc/BRIEF.md
# Shared RAM Access Arbiter

This block lets two agents share one single-port RAM of 16-bit words. The first agent is a fast host bus running on the block's clock. The second is a serial message receiver in another clock domain, which deposits message bytes, whole words and a last-message pointer. The block synchronizes each receiver request into the bus clock and parks it in a one-entry holding slot until the RAM is free. It then drives the RAM address select, the address, the write data, one write strobe per byte lane and a read enable. The RAM array and the bus protocol decode are not part of the block.

The receiver signals a new request by inverting `rxTgl`. The kind, lane, address and data inputs must already be stable at that moment and must stay stable for three clocks. The host holds `busReq` until it sees a cycle with `busWait` low, and the access is performed in that cycle. A receiver request that arrives while the slot is still occupied is discarded, and `overrunErr` pulses.

Top module: `ramshare_arbiter`

## Requirements
- R1: With the RAM free, a host request is served in the same cycle with `busWait` low. A read or an interrupt acknowledge asserts `ramRe`. A write (`busWe`=1, `busIack`=0) asserts both `ramWe` lanes. Select code 0 routes `busAddr` and `busWdata`. The cycle after a host access carries no strobe, and read and write never coincide.
- R2: A host request made while the RAM is held (the release cycle after a host access, or a receiver write cycle) sees `busWait`=1 and produces no host strobe.
- R3: When a host request and a queued receiver request compete in the same free cycle, the host is served first and the receiver write follows later.
- R4: Inverting `rxTgl` with the RAM free and the slot empty produces the receiver write in the fourth cycle after the cycle of the inversion.
- R5: Receiver kind encoding on `rxKind`: 00 byte, 01 word, 10 pointer, 11 word. A word write asserts both lanes with `rxData` unchanged, select code 1 and address `rxAddr`. A byte write asserts only `ramWe[1]` when `rxOdd`=1 or only `ramWe[0]` when `rxOdd`=0, and puts `rxData[7:0]` on both bytes of `ramWdata`.
- R6: A pointer write uses select code 2, address 0, both lanes and `rxData` unchanged.
- R7: An interrupt acknowledge (`busIack`=1) uses select code 3, address 2 plus `busVec`, and `ramRe`, with no write strobe.
- R8: A receiver request arriving while the slot holds an entry that is not being written in that cycle is discarded. `overrunErr` is high for exactly the following cycle, and the queued entry is still written once with its own data.
- R9: During reset, no strobe is active, `overrunErr` is 0 and select code 0 is driven.
- R10: A receiver write holds its strobes for exactly one clock and happens once per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busReq | input | 1 | Host access request, held until served |
| busWe | input | 1 | Host write (1) or read (0) |
| busIack | input | 1 | Host interrupt-acknowledge read of a vector word |
| busVec | input | 1 | Which vector word is acknowledged |
| busAddr | input | AW | Host word address |
| busWdata | input | DW | Host write data |
| busWait | output | 1 | Host must hold its request |
| rxTgl | input | 1 | Receiver request, signalled by inversion (other clock domain) |
| rxKind | input | 2 | Receiver request kind |
| rxOdd | input | 1 | Byte request targets the high lane |
| rxAddr | input | AW | Receiver store address |
| rxData | input | DW | Receiver write data |
| ramSel | output | 2 | Address source code: 0 host, 1 receiver, 2 pointer, 3 vector |
| ramAddr | output | AW | Selected RAM address |
| ramWdata | output | DW | Selected RAM write data |
| ramWe | output | 2 | Write strobes, bit 1 high byte, bit 0 low byte |
| ramRe | output | 1 | RAM read enable |
| overrunErr | output | 1 | One-cycle pulse when a receiver request is lost |

## Verification
A stuck or mis-sequenced owner state shows up in the first host request after it. That request either gets a strobe while `busWait` is high, or gets a wait where the RAM was free. A holding slot that fails to fill or to clear shows up four cycles after an inversion of `rxTgl`, as a missing receiver write or a repeated one. A wrong overrun decision shows up one cycle after the second request, either as a missing or spurious `overrunErr` pulse or as the later receiver write carrying the newer data instead of the queued data.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    SEL_BUS = 2'd0,
    SEL_RX  = 2'd1,
    SEL_PTR = 2'd2,
    SEL_VEC = 2'd3
  } addrSel_e;

  typedef enum logic [1:0] {
    OWN_IDLE   = 2'd0,
    OWN_BUSREL = 2'd1,
    OWN_RX     = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    RK_BYTE  = 2'd0,
    RK_WORD  = 2'd1,
    RK_PTR   = 2'd2,
    RK_WORD2 = 2'd3
  } rxKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the holding slot this cycle
    logic busGo;    // host access performed this cycle
    logic rxGo;     // receiver write performed this cycle
  } ctrlStrb_t;

endpackage

// File: rtl/arb_rx_sync.sv
module arb_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tglIn,
  output logic evt
);
  localparam int LAST = STAGES;

  logic [LAST:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[LAST-1:0], tglIn};
  end

  // one pulse per inversion of the toggle, after STAGES flops
  assign evt = pipe[LAST] ^ pipe[LAST-1];

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busReq,
  input  logic      rxEvt,
  output ctrlStrb_t strb,
  output logic      busWait,
  output logic      overrunErr
);
  owner_e own, ownNext;
  logic   pend;

  always_comb begin
    strb.busGo   = busReq && (own == OWN_IDLE);
    strb.rxGo    = (own == OWN_RX);
    // slot is free, or its entry is written in this very cycle
    strb.capture = rxEvt && (!pend || own == OWN_RX);
  end

  assign busWait = busReq && (own != OWN_IDLE);

  always_comb begin
    ownNext = OWN_IDLE;
    unique case (own)
      OWN_IDLE: begin
        if (busReq)    ownNext = OWN_BUSREL;  // host wins ties
        else if (pend) ownNext = OWN_RX;
      end
      OWN_BUSREL: ownNext = OWN_IDLE;
      OWN_RX:     ownNext = OWN_IDLE;
      default:    ownNext = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own        <= OWN_IDLE;
      pend       <= 1'b0;
      overrunErr <= 1'b0;
    end else begin
      own        <= ownNext;
      overrunErr <= rxEvt && pend && (own != OWN_RX);
      if (strb.capture)       pend <= 1'b1;
      else if (own == OWN_RX) pend <= 1'b0;
    end
  end

endmodule

// File: rtl/arb_dpath.sv
module arb_dpath
  import arb_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 16,
  parameter int VEC_BASE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrb_t     strb,
  input  logic          busWe,
  input  logic          busIack,
  input  logic          busVec,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  input  logic [1:0]    rxKind,
  input  logic          rxOdd,
  input  logic [AW-1:0] rxAddr,
  input  logic [DW-1:0] rxData,
  output addrSel_e      ramSel,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWdata,
  output logic [1:0]    ramWe,
  output logic          ramRe
);
  localparam int BW = DW / 2;
  localparam logic [AW-1:0] VEC_ADDR = AW'(VEC_BASE);

  rxKind_e       qKind;
  logic          qOdd;
  logic [AW-1:0] qAddr;
  logic [DW-1:0] qData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qKind <= RK_BYTE;
      qOdd  <= 1'b0;
      qAddr <= '0;
      qData <= '0;
    end else if (strb.capture) begin
      qKind <= rxKind_e'(rxKind);
      qOdd  <= rxOdd;
      qAddr <= rxAddr;
      qData <= rxData;
    end
  end

  always_comb begin
    ramSel   = SEL_BUS;
    ramAddr  = busAddr;
    ramWdata = busWdata;
    if (strb.rxGo) begin
      if (qKind == RK_PTR) begin
        ramSel  = SEL_PTR;
        ramAddr = '0;
      end else begin
        ramSel  = SEL_RX;
        ramAddr = qAddr;
      end
      ramWdata = (qKind == RK_BYTE) ? {2{qData[BW-1:0]}} : qData;
    end else if (strb.busGo && busIack) begin
      ramSel  = SEL_VEC;
      ramAddr = VEC_ADDR | AW'(busVec);
    end
  end

  assign ramRe = strb.busGo && (!busWe || busIack);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic laneHit;
    assign laneHit  = (qKind != RK_BYTE) || (qOdd == (g == 1));
    assign ramWe[g] = (strb.busGo && busWe && !busIack) || (strb.rxGo && laneHit);
  end

endmodule

// File: rtl/ramshare_arbiter.sv
module ramshare_arbiter
  import arb_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 16,
  parameter int VEC_BASE    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busReq,
  input  logic          busWe,
  input  logic          busIack,
  input  logic          busVec,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic          busWait,
  input  logic          rxTgl,
  input  logic [1:0]    rxKind,
  input  logic          rxOdd,
  input  logic [AW-1:0] rxAddr,
  input  logic [DW-1:0] rxData,
  output logic [1:0]    ramSel,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramWdata,
  output logic [1:0]    ramWe,
  output logic          ramRe,
  output logic          overrunErr
);
  logic      rxEvt;
  ctrlStrb_t strb;
  addrSel_e  selInt;

  arb_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .tglIn(rxTgl), .evt(rxEvt)
  );

  arb_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .busReq(busReq), .rxEvt(rxEvt),
    .strb(strb), .busWait(busWait), .overrunErr(overrunErr)
  );

  arb_dpath #(.AW(AW), .DW(DW), .VEC_BASE(VEC_BASE)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .busWe(busWe), .busIack(busIack), .busVec(busVec),
    .busAddr(busAddr), .busWdata(busWdata),
    .rxKind(rxKind), .rxOdd(rxOdd), .rxAddr(rxAddr), .rxData(rxData),
    .ramSel(selInt), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .ramWe(ramWe), .ramRe(ramRe)
  );

  assign ramSel = selInt;

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busReq,
  input logic          busWait,
  input logic [1:0]    ramSel,
  input logic [AW-1:0] ramAddr,
  input logic [1:0]    ramWe,
  input logic          ramRe,
  input logic          overrunErr
);
  logic busAcc, rxAcc;
  assign busAcc = ramRe || (ramSel == 2'd0 && ramWe != 2'b00);
  assign rxAcc  = (ramSel == 2'd1 || ramSel == 2'd2) && ramWe != 2'b00;

  // R1: host access is followed by a quiet release cycle
  a_r1_release_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && !busWait && busAcc) |=> (ramWe == 2'b00 && !ramRe));

  // R1: never read and write together
  a_r1_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramRe && ramWe != 2'b00));

  // R2: a waiting host gets no strobe
  a_r2_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busWait |-> !busAcc);

  // R5: a single lane only for receiver byte writes
  a_r5_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (ramWe == 2'b01 || ramWe == 2'b10) |-> ramSel == 2'd1);

  // R6: pointer writes go to word zero on both lanes
  a_r6_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ramSel == 2'd2) |-> (ramAddr == '0 && ramWe == 2'b11));

  // R7: vector select is a read of word 2 or 3
  a_r7_vec_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ramSel == 2'd3) |-> (ramRe && ramWe == 2'b00 && ramAddr[AW-1:1] == 1));

  // R10: a receiver write lasts one clock
  a_r10_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rxAcc |=> !rxAcc);

  // R9: no overrun pulse straight out of reset
  a_r9_quiet_reset: assert property (@(posedge clk)
    !rst_n |-> !overrunErr);

endmodule

bind ramshare_arbiter arb_checker #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busReq(busReq), .busWait(busWait),
  .ramSel(ramSel), .ramAddr(ramAddr), .ramWe(ramWe), .ramRe(ramRe),
  .overrunErr(overrunErr)
);

// File: tb/ramshare_arbiter_tb.sv
module ramshare_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam logic [AW-1:0] B_ADDR = 7'h09;
  localparam logic [AW-1:0] R_ADDR = 7'h12;
  localparam int NV = 48;

  // {req[3:0], bReq bWe bIack bVec, rTgl kind[1:0] odd, we1 we0 re, sel[1:0], wait ovr}
  localparam logic [18:0] VECS [NV] = '{
    19'b0001_1000_0010_001_00_00, // c0  R1 read
    19'b0001_0000_0010_000_00_00, // c1  R1 release
    19'b0001_1100_0010_110_00_00, // c2  R1 write
    19'b0010_1100_0010_000_00_10, // c3  R2 wait in release
    19'b0001_1100_0010_110_00_00, // c4  R1
    19'b0001_0000_0010_000_00_00, // c5
    19'b0100_0000_1010_000_00_00, // c6  R4 toggle, word
    19'b0100_0000_1010_000_00_00, // c7
    19'b0100_0000_1010_000_00_00, // c8
    19'b0100_0000_1010_000_00_00, // c9
    19'b0100_0000_1010_110_01_00, // c10 R4 write
    19'b0100_0000_1010_000_00_00, // c11
    19'b0101_0000_0001_000_00_00, // c12 R5 byte odd
    19'b0101_0000_0001_000_00_00, // c13
    19'b0101_0000_0001_000_00_00, // c14
    19'b0011_1000_0001_001_00_00, // c15 R3 host wins
    19'b0011_0000_0001_000_00_00, // c16
    19'b0011_0000_0001_000_00_00, // c17
    19'b0010_1000_0001_100_01_10, // c18 R2 wait, R5 high lane
    19'b0001_1100_0001_110_00_00, // c19
    19'b0001_0000_0001_000_00_00, // c20
    19'b0101_0000_1000_000_00_00, // c21 R5 byte even
    19'b0101_0000_1000_000_00_00, // c22
    19'b0101_0000_1000_000_00_00, // c23
    19'b0101_0000_1000_000_00_00, // c24
    19'b0101_0000_1000_010_01_00, // c25 R5 low lane
    19'b0101_0000_1000_000_00_00, // c26
    19'b0110_0000_0100_000_00_00, // c27 R6 pointer
    19'b0110_0000_0100_000_00_00, // c28
    19'b0110_0000_0100_000_00_00, // c29
    19'b0110_0000_0100_000_00_00, // c30
    19'b0110_0000_0100_110_10_00, // c31 R6 write
    19'b0110_0000_0100_000_00_00, // c32
    19'b0111_1011_0100_001_11_00, // c33 R7 vector 1
    19'b0111_0000_0100_000_00_00, // c34
    19'b0111_1010_0100_001_11_00, // c35 R7 vector 0
    19'b0111_0000_0100_000_00_00, // c36
    19'b1000_1000_1010_001_00_00, // c37 R8 first request
    19'b1000_1000_1010_000_00_10, // c38
    19'b1000_1000_1010_001_00_00, // c39
    19'b1000_1000_0010_000_00_10, // c40 second request
    19'b1000_1000_0010_001_00_00, // c41
    19'b1000_1000_0010_000_00_10, // c42
    19'b1000_1000_0010_001_00_01, // c43 R8 pulse
    19'b1000_0000_0010_000_00_00, // c44
    19'b1000_0000_0010_000_00_00, // c45
    19'b1000_0000_0010_110_01_00, // c46 queued entry written
    19'b1000_0000_0010_000_00_00  // c47
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busReq = 0, busWe = 0, busIack = 0, busVec = 0;
  logic [AW-1:0] busAddr = B_ADDR;
  logic [DW-1:0] busWdata = 16'h0000;
  logic busWait;
  logic rxTgl = 0, rxOdd = 0;
  logic [1:0] rxKind = 2'b01;
  logic [AW-1:0] rxAddr = R_ADDR;
  logic [DW-1:0] rxData = 16'h0000;
  logic [1:0] ramSel;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWdata;
  logic [1:0] ramWe;
  logic ramRe, overrunErr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramshare_arbiter #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .busReq(busReq), .busWe(busWe), .busIack(busIack),
    .busVec(busVec), .busAddr(busAddr), .busWdata(busWdata), .busWait(busWait),
    .rxTgl(rxTgl), .rxKind(rxKind), .rxOdd(rxOdd), .rxAddr(rxAddr), .rxData(rxData),
    .ramSel(ramSel), .ramAddr(ramAddr), .ramWdata(ramWdata), .ramWe(ramWe),
    .ramRe(ramRe), .overrunErr(overrunErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // step to next negedge and sample shortly after
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // watch a window, count receiver writes, keep data and lanes of the last
  task automatic watchRx(input int cycles, output int cnt,
                         output logic [DW-1:0] dat, output logic [1:0] we);
    cnt = 0; dat = '0; we = '0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (ramWe != 2'b00 && (ramSel == 2'd1 || ramSel == 2'd2)) begin
        cnt++; dat = ramWdata; we = ramWe;
      end
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [DW-1:0] dat;
    logic [1:0] we;
    logic [18:0] v;
    logic [AW-1:0] expAddr;

    // R9 reset state
    repeat (3) @(negedge clk);
    #1;
    check("R9 strobes", {ramWe, ramRe}, 3'b000);
    check("R9 overrun", overrunErr, 1'b0);
    check("R9 sel", ramSel, 2'd0);
    check("R9 wait", busWait, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      @(negedge clk);
      {busReq, busWe, busIack, busVec} = v[14:11];
      {rxTgl, rxKind, rxOdd} = v[10:7];
      #1;
      case (v[3:2])
        2'd0: expAddr = B_ADDR;
        2'd1: expAddr = R_ADDR;
        2'd2: expAddr = '0;
        default: expAddr = 7'd2 | AW'(busVec);
      endcase
      nChecks++;
      if ({ramWe, ramRe, ramSel, busWait, overrunErr} !== v[6:0] || ramAddr !== expAddr) begin
        nFails++;
        $display("FAIL R%0d vector %0d actual=%b/%h expected=%b/%h", v[18:15], i,
                 {ramWe, ramRe, ramSel, busWait, overrunErr}, ramAddr, v[6:0], expAddr);
      end
    end

    // R1 host write data passes through
    @(negedge clk);
    busWdata = 16'hBEEF; busReq = 1; busWe = 1; busIack = 0;
    #1;
    check("R1 wdata", ramWdata, 16'hBEEF);
    check("R1 lanes", ramWe, 2'b11);
    step();
    busReq = 0; busWe = 0;
    step();

    // R5 word data, R10 exactly one write
    rxKind = 2'b01; rxData = 16'hA55A; rxTgl = ~rxTgl;
    watchRx(8, cnt, dat, we);
    check("R10 single word write", cnt, 1);
    check("R5 word data", dat, 16'hA55A);
    check("R5 word lanes", we, 2'b11);

    // R5 odd byte duplicated
    rxKind = 2'b00; rxOdd = 1; rxData = 16'h1234; rxTgl = ~rxTgl;
    watchRx(8, cnt, dat, we);
    check("R5 byte count", cnt, 1);
    check("R5 byte dup", dat, 16'h3434);
    check("R5 byte lane", we, 2'b10);

    // R5 kind 11 acts as word
    rxKind = 2'b11; rxData = 16'h0F0E; rxTgl = ~rxTgl;
    watchRx(8, cnt, dat, we);
    check("R5 kind11 data", dat, 16'h0F0E);
    check("R5 kind11 lanes", we, 2'b11);

    // R8 overrun keeps the queued data and drops the newer one
    busReq = 1; busWe = 0;
    rxKind = 2'b01; rxData = 16'h1111; rxTgl = ~rxTgl;
    repeat (4) step();
    rxData = 16'h2222; rxTgl = ~rxTgl;
    repeat (5) step();
    busReq = 0;
    watchRx(8, cnt, dat, we);
    check("R8 one write after overrun", cnt, 1);
    check("R8 queued data kept", dat, 16'h1111);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule